// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limiter

This block sits in one bridge leg, between the PWM generator and the gate sequencer. It watches a digital overcurrent flag from a comparator on the leg's sense path. Each rising PWM edge starts a programmable blanking window. The flag is ignored inside that window so that switching spikes cannot trip it. After the window closes, an asserted flag latches a limit condition for the rest of the PWM period. While the limit is latched, the high-side command is held off whatever the PWM does. The latch clears only on the period-start strobe.

The synchronous-rectification enable is sampled on the edge that latches the limit. If it was set, the low-side command stays on for as long as the limit lasts. If it was clear, both commands stay off. When no limit is latched, the high side follows PWM. In that state the low side is the complement of PWM when rectification is enabled and is off when it is not. A one-cycle event pulse and a per-period status bit are brought out for diagnostics.

Top module: `climit_top`

## Requirements
- R1: During reset and after it, with no limit latched, `limit_active` and `limit_pulse` are 0. `hs_cmd` equals `pwm_in` in the same cycle. `ls_cmd` equals `sync_rect_en & ~pwm_in`.
- R2: A rising edge of `pwm_in` is seen at clock edge E0. The flag is ignored at E0 and at the next `blank_cycles` edges (E1..EN). A flag that is high only inside that window never latches a limit.
- R3: A limit latches on a clock edge where `pwm_in` is 1, the flag is 1, and the edge is outside the blanking window. `limit_active` reads 1 right after that edge.
- R4: While `limit_active` is 1, `hs_cmd` is 0, including across later PWM rising edges in the same period.
- R5: The latched limit stays set when the flag falls. Only an edge with `period_start`=1 clears it. If a trip and `period_start` fall on the same edge, the clear wins and no limit latches.
- R6: If `sync_rect_en` is 1 on the edge that latches the limit, `ls_cmd` is 1 until the limit clears, even if the enable falls afterwards.
- R7: If `sync_rect_en` is 0 on the edge that latches the limit, `hs_cmd` and `ls_cmd` are both 0 while the limit lasts.
- R8: `limit_pulse` is 1 for exactly the one cycle that follows the latching edge. A period with a limit already latched produces no further pulse.
- R9: Every rising PWM edge reloads the blanking count from `blank_cycles`, including a rising edge that comes while an earlier window is still running.
- R10: The flag is ignored on any edge where `pwm_in` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | PWM command from the generator (1 = high side on) |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| oc_flag | input | 1 | Overcurrent comparator flag |
| blank_cycles | input | BLANK_W | Blanking length in clock cycles after a PWM rising edge |
| sync_rect_en | input | 1 | Enables low-side drive while a limit is latched and during PWM-off |
| hs_cmd | output | 1 | High-side switch command |
| ls_cmd | output | 1 | Low-side switch command |
| limit_pulse | output | 1 | One-cycle pulse after a limit latches |
| limit_active | output | 1 | Limit latched in the current period |

## Verification
The switch commands are combinational from the inputs and the latch state. They are therefore checked in the same cycle an input changes. `limit_active`, `limit_pulse` and the commands that depend on the limit change one edge after the tripping edge. The bench drives every input one time unit after a rising edge. It samples after the next edge, so each check sits exactly one edge after the stimulus it judges. The blanking tests count edges from the PWM rise. They expect a zero status through E0..EN and the latch at E(N+1). This pins the window length to the cycle.

// File: rtl/climit_pkg.sv
package climit_pkg;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_cmd_t;

  // Next blanking count: reload on a rise, else count down to zero.
  function automatic logic [31:0] blank_next(input logic [31:0] cnt,
                                             input logic [31:0] load,
                                             input logic        rise);
    if (rise)
      return load;
    else if (cnt != 32'd0)
      return cnt - 32'd1;
    else
      return 32'd0;
  endfunction

  // A flag qualifies when the high side is commanded, the window is
  // closed and no limit is held yet.
  function automatic logic trip_ok(input logic flag,
                                   input logic pwm,
                                   input logic blanked,
                                   input logic latched);
    return flag & pwm & ~blanked & ~latched;
  endfunction

  // Switch commands from PWM and latch state.
  function automatic leg_cmd_t leg_cmd(input logic pwm,
                                       input logic latched,
                                       input logic sr_latched,
                                       input logic sr_now);
    leg_cmd_t c;
    if (latched) begin
      c.hs = 1'b0;
      c.ls = sr_latched;
    end else begin
      c.hs = pwm;
      c.ls = sr_now & ~pwm;
    end
    return c;
  endfunction

endpackage

// File: rtl/climit_blank.sv
module climit_blank #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_in,
  input  logic [BLANK_W-1:0] blank_cycles,
  output logic               pwm_rise,
  output logic               blank_win
);
  import climit_pkg::*;

  localparam logic [BLANK_W-1:0] CNT_ZERO = '0;

  logic               pwm_q;
  logic [BLANK_W-1:0] cnt_q;
  logic [BLANK_W-1:0] cnt_d;
  logic [31:0]        cnt_wide;

  assign pwm_rise = pwm_in & ~pwm_q;
  assign cnt_wide = blank_next(32'(cnt_q), 32'(blank_cycles), pwm_rise);
  assign cnt_d    = cnt_wide[BLANK_W-1:0];
  assign blank_win = pwm_rise | (cnt_q != CNT_ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      cnt_q <= CNT_ZERO;
    end else begin
      pwm_q <= pwm_in;
      cnt_q <= cnt_d;
    end
  end

  // R9: every rise reloads the count
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_rise |=> (cnt_q == $past(blank_cycles)));

  // R2: the count only moves down between rises
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_rise && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/climit_latch.sv
module climit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic oc_flag,
  input  logic blank_win,
  input  logic period_start,
  input  logic sync_rect_en,
  output logic limit_q,
  output logic sr_q,
  output logic limit_pulse,
  output logic trip_evt
);
  import climit_pkg::*;

  logic take;

  assign trip_evt = trip_ok(oc_flag, pwm_in, blank_win, limit_q);
  assign take     = trip_evt & ~period_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q     <= 1'b0;
      sr_q        <= 1'b0;
      limit_pulse <= 1'b0;
    end else begin
      limit_pulse <= take;
      if (period_start) begin
        limit_q <= 1'b0;
        sr_q    <= 1'b0;
      end else if (take) begin
        limit_q <= 1'b1;
        sr_q    <= sync_rect_en;
      end
    end
  end

  // R2: no latch can start from an edge inside the window
  a_r2_blank_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    blank_win |=> !limit_pulse);

  // R10: PWM low never trips
  a_r10_pwm_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> !limit_pulse);

  // R5: latch holds until the period strobe
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q && !period_start) |=> limit_q);

  // R5: strobe always clears
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !limit_q);

  // R8: single-cycle pulse that coincides with a fresh latch
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    limit_pulse |=> !limit_pulse);

  a_r8_with_latch: assert property (@(posedge clk) disable iff (!rst_n)
    limit_pulse |-> (limit_q && !$past(limit_q)));

endmodule

// File: rtl/climit_leg_out.sv
module climit_leg_out (
  input  logic pwm_in,
  input  logic limit_q,
  input  logic sr_q,
  input  logic sync_rect_en,
  output logic hs_cmd,
  output logic ls_cmd
);
  import climit_pkg::*;

  leg_cmd_t cmd;

  assign cmd    = leg_cmd(pwm_in, limit_q, sr_q, sync_rect_en);
  assign hs_cmd = cmd.hs;
  assign ls_cmd = cmd.ls;

  // Shoot-through guard: never both on
  always_comb begin
    a_r4_no_overlap: assert (!(hs_cmd && ls_cmd));
  end

endmodule

// File: rtl/climit_top.sv
module climit_top #(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_in,
  input  logic               period_start,
  input  logic               oc_flag,
  input  logic [BLANK_W-1:0] blank_cycles,
  input  logic               sync_rect_en,
  output logic               hs_cmd,
  output logic               ls_cmd,
  output logic               limit_pulse,
  output logic               limit_active
);

  logic pwm_rise;
  logic blank_win;
  logic limit_q;
  logic sr_q;
  logic trip_evt;

  climit_blank #(.BLANK_W(BLANK_W)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_in       (pwm_in),
    .blank_cycles (blank_cycles),
    .pwm_rise     (pwm_rise),
    .blank_win    (blank_win)
  );

  climit_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_in       (pwm_in),
    .oc_flag      (oc_flag),
    .blank_win    (blank_win),
    .period_start (period_start),
    .sync_rect_en (sync_rect_en),
    .limit_q      (limit_q),
    .sr_q         (sr_q),
    .limit_pulse  (limit_pulse),
    .trip_evt     (trip_evt)
  );

  climit_leg_out u_out (
    .pwm_in       (pwm_in),
    .limit_q      (limit_q),
    .sr_q         (sr_q),
    .sync_rect_en (sync_rect_en),
    .hs_cmd       (hs_cmd),
    .ls_cmd       (ls_cmd)
  );

  assign limit_active = limit_q;

  // R4: high side off while limited
  a_r4_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
    limit_active |-> !hs_cmd);

  // R6: enable seen at the latching edge keeps the low side on
  a_r6_ls_on: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_pulse && $past(sync_rect_en)) |-> ls_cmd);

  // R7: without rectification both commands are off
  a_r7_both_off: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_pulse && !$past(sync_rect_en)) |-> (!ls_cmd && !hs_cmd));

  // R3: a trip outside a strobe edge latches
  a_r3_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_evt && !period_start && !pwm_rise) |=> limit_active);

endmodule

// File: tb/climit_top_tb.sv
module climit_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwm_in = 1'b0;
  logic          period_start = 1'b0;
  logic          oc_flag = 1'b0;
  logic [BW-1:0] blank_cycles = '0;
  logic          sync_rect_en = 1'b0;
  logic          hs_cmd, ls_cmd, limit_pulse, limit_active;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  climit_top #(.BLANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .oc_flag(oc_flag), .blank_cycles(blank_cycles), .sync_rect_en(sync_rect_en),
    .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .limit_pulse(limit_pulse),
    .limit_active(limit_active)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_period();
    pwm_in = 1'b0; oc_flag = 1'b0; period_start = 1'b1;
    step();
    period_start = 1'b0;
    step();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset limit_active", limit_active, 1'b0);
    chk("R1 reset limit_pulse", limit_pulse, 1'b0);
    chk("R1 reset hs", hs_cmd, 1'b0);
    chk("R1 reset ls", ls_cmd, 1'b0);
    step(); step();
    rst_n = 1'b1;
    step();
    pwm_in = 1'b1;
    #1;
    chk("R1 hs follows pwm", hs_cmd, 1'b1);
    chk("R1 ls off when pwm high", ls_cmd, 1'b0);
    step();
    pwm_in = 1'b0; sync_rect_en = 1'b1;
    #1;
    chk("R1 hs follows pwm low", hs_cmd, 1'b0);
    chk("R1 ls complement with rectification", ls_cmd, 1'b1);
    sync_rect_en = 1'b0;
    #1;
    chk("R1 ls off without rectification", ls_cmd, 1'b0);
    step();
  endtask

  task automatic t_pwm_low();
    idle_period();
    blank_cycles = 8'd0;
    oc_flag = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R10 flag with pwm low", limit_active, 1'b0);
    end
    oc_flag = 1'b0;
  endtask

  task automatic t_blank();
    idle_period();
    blank_cycles = 8'd3; sync_rect_en = 1'b0;
    pwm_in = 1'b1; oc_flag = 1'b1;
    step();
    chk("R2 blanked at rise edge", limit_active, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R2 blanked in window", limit_active, 1'b0);
      chk("R2 hs on in window", hs_cmd, 1'b1);
    end
    step();
    chk("R3 latched after window", limit_active, 1'b1);
    chk("R8 pulse after latch", limit_pulse, 1'b1);
    chk("R4 hs off when limited", hs_cmd, 1'b0);
    chk("R7 ls off without rectification", ls_cmd, 1'b0);
    step();
    chk("R8 pulse one cycle", limit_pulse, 1'b0);
    oc_flag = 1'b0;
  endtask

  task automatic t_hold();
    pwm_in = 1'b0;
    step();
    chk("R5 holds after flag drops", limit_active, 1'b1);
    pwm_in = 1'b1; oc_flag = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R4 hs off after new rise", hs_cmd, 1'b0);
      chk("R8 no second pulse", limit_pulse, 1'b0);
    end
    oc_flag = 1'b0; period_start = 1'b1;
    step();
    period_start = 1'b0;
    chk("R5 cleared by period start", limit_active, 1'b0);
    chk("R5 hs restored", hs_cmd, 1'b1);
  endtask

  task automatic t_short_flag();
    idle_period();
    blank_cycles = 8'd4;
    pwm_in = 1'b1; oc_flag = 1'b1;
    for (int k = 0; k <= 4; k++) step();
    oc_flag = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R2 flag only in window ignored", limit_active, 1'b0);
    end
  endtask

  task automatic t_sync_rect();
    idle_period();
    blank_cycles = 8'd0; sync_rect_en = 1'b1;
    pwm_in = 1'b1; oc_flag = 1'b1;
    step();
    chk("R2 zero window still blanks rise edge", limit_active, 1'b0);
    step();
    chk("R3 latched with zero window", limit_active, 1'b1);
    chk("R6 ls on when limited", ls_cmd, 1'b1);
    chk("R4 hs off", hs_cmd, 1'b0);
    sync_rect_en = 1'b0; oc_flag = 1'b0;
    step();
    chk("R6 ls kept after enable falls", ls_cmd, 1'b1);
    period_start = 1'b1;
    step();
    period_start = 1'b0;
    chk("R6 ls follows idle rule after clear", ls_cmd, 1'b0);
  endtask

  task automatic t_restart();
    idle_period();
    blank_cycles = 8'd5;
    pwm_in = 1'b1;
    step(); step(); step();
    pwm_in = 1'b0;
    step();
    pwm_in = 1'b1; oc_flag = 1'b1;
    step();
    for (int k = 1; k <= 5; k++) begin
      step();
      chk("R9 window restarted by rise", limit_active, 1'b0);
    end
    step();
    chk("R9 latch after restarted window", limit_active, 1'b1);
    oc_flag = 1'b0;
  endtask

  task automatic t_priority();
    idle_period();
    blank_cycles = 8'd0;
    pwm_in = 1'b1; oc_flag = 1'b1;
    step();
    period_start = 1'b1;
    step();
    period_start = 1'b0;
    chk("R5 strobe beats trip", limit_active, 1'b0);
    chk("R5 no pulse on strobe edge", limit_pulse, 1'b0);
    step();
    chk("R3 trip on next edge", limit_active, 1'b1);
    oc_flag = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_pwm_low();
    t_blank();
    t_hold();
    t_short_flag();
    t_sync_rect();
    t_restart();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule